// File: doc/BRIEF.md
# Launch-Capture Phase Sweep Controller

This controller runs one delay-measurement pass for a single two-vector challenge applied to a combinational unit. The launch row holds the first vector. A capture row is clocked by a second clock whose phase can be moved in fine steps. An XOR per output compares what the capture row holds with the first vector. When the controller receives a start pulse, it does the following in order:

- Clears the evaluation unit's timing registers.
- Places the capture-clock phase at its starting step.
- Enters a loop: switch the launch mux to the second vector, let the paths settle, fire the evaluation strobe, and if any XOR output is still high, ask the phase shifter for one more step.

The sweep ends on data. When every XOR output reads zero at evaluation time, the controller returns to idle and raises a done flag that software polls. The step count at that point is the delay measure.

The phase shifter is reached through a request/busy/acknowledge handshake. A request is either "set to start step" or "advance one step". The shifter needs many cycles to complete one, so the controller holds off the next launch until the acknowledge arrives. A hard step limit stops a sweep whose outputs never settle, and it flags a timeout.

Top module: `lcs_sweep_ctrl`

## Requirements
- R1: During and after reset, `busy_o`, `done_o`, `timeout_o`, `launch_o`, `eval_go_o`, `eval_clr_o` and `ph_req_o` are 0 and `step_o` is 0.
- R2: A `start_i` sampled high while idle makes `busy_o` rise in the next cycle. In that same cycle `eval_clr_o` is high for exactly one cycle, and `done_o`, `timeout_o` and `step_o` return to 0.
- R3: The cycle after the clear, `ph_req_o` rises with `ph_set_o`=1 (set to start step). When that request is acknowledged, `step_o` becomes START_STEP (default 1).
- R4: `ph_req_o` stays high while `ph_busy_i` is 1. It is accepted on the first edge where `ph_busy_i` is 0. After that the controller waits, with no launch, until `ph_ack_i`, and `launch_o` rises in the cycle after the acknowledge is sampled.
- R5: `launch_o` is high for SETTLE_CYC cycles. Then `eval_go_o` is high for one cycle with `launch_o` still high.
- R6: If any bit of `xor_i` is 1 at the evaluation cycle and `step_o` is below MAX_STEP, the next cycle drops `launch_o` and raises `ph_req_o` with `ph_set_o`=0 (advance). On that acknowledge, `step_o` increases by exactly 1.
- R7: If all bits of `xor_i` are 0 at the evaluation cycle, the next cycle has `busy_o`=0, `done_o`=1 and `timeout_o`=0, and `step_o` keeps the final step.
- R8: If `xor_i` is nonzero at evaluation while `step_o` equals MAX_STEP (default 2047), the sweep ends with `done_o`=1 and `timeout_o`=1, and no further request is issued.
- R9: A `start_i` pulse while `busy_o` is 1 has no effect on any output or on the sweep length.
- R10: `done_o` and `timeout_o` hold their values until the next accepted start.
- R11: A `ph_ack_i` pulse while no shifter request is outstanding has no effect.
- R12: With a shifter latency of L cycles from acceptance to acknowledge, a sweep that performs K evaluations keeps `busy_o` high for 1 + K·(L + SETTLE_CYC + 3) cycles. The final step is max(START_STEP, largest settling threshold), where an output reads 1 while its threshold exceeds the current step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Launch-side clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request for one sweep |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | Sweep finished, held until next start |
| timeout_o | output | 1 | Sweep hit the step limit |
| step_o | output | STEP_W | Current phase step applied to the capture clock |
| eval_clr_o | output | 1 | One-cycle clear of the evaluation unit's timing registers |
| eval_go_o | output | 1 | One-cycle evaluation strobe |
| launch_o | output | 1 | Launch mux select: 1 applies the second vector |
| ph_req_o | output | 1 | Phase shifter request, held until accepted |
| ph_set_o | output | 1 | Request kind: 1 set to start step, 0 advance one step |
| ph_busy_i | input | 1 | Phase shifter is working |
| ph_ack_i | input | 1 | Phase shifter completed the request |
| xor_i | input | N_OUT | Capture-side transition-detect outputs |

## Verification
On every cycle, the bound checker checks the following: the one-hot relation among the clear, evaluate and request strobes; that the evaluation strobe falls inside the launch window; that a request is held while the shifter is busy; that the step only moves by one or resets; and that done, timeout and busy stay consistent with each other. The bench scenarios cover the behaviours that need a full sweep: the exact cycle count, the termination step chosen by the settling thresholds, the timeout after 2047 steps, and the absence of any effect from stray start and acknowledge pulses, since those depend on what the outputs do many cycles later.

// File: rtl/lcs_pkg.sv
package lcs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_CLEAR  = 3'd1,
    ST_PREQ   = 3'd2,
    ST_PWAIT  = 3'd3,
    ST_LAUNCH = 3'd4,
    ST_EVAL   = 3'd5
  } lcs_state_e;

endpackage

// File: rtl/lcs_step_ctr.sv
module lcs_step_ctr #(
  parameter int MAX_STEP   = 2047,
  parameter int START_STEP = 1,
  parameter int STEP_W     = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic              inc_i,
  output logic [STEP_W-1:0] step_o,
  output logic              at_limit_o
);

  localparam logic [STEP_W-1:0] START_V = STEP_W'(START_STEP);
  localparam logic [STEP_W-1:0] LIMIT_V = STEP_W'(MAX_STEP);

  logic [STEP_W-1:0] step_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      step_q <= '0;
    end else if (load_i) begin
      step_q <= START_V;
    end else if (inc_i && (step_q != LIMIT_V)) begin
      step_q <= step_q + 1'b1;
    end
  end

  assign step_o     = step_q;
  assign at_limit_o = (step_q == LIMIT_V);

endmodule

// File: rtl/lcs_dwell_tmr.sv
module lcs_dwell_tmr #(
  parameter int SETTLE_CYC = 4,
  parameter int CNT_W      = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  input  logic run_i,
  output logic expired_o
);

  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(SETTLE_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= RELOAD;
    end else if (run_i && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/lcs_seq_fsm.sv
module lcs_seq_fsm
  import lcs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic ph_busy_i,
  input  logic ph_ack_i,
  input  logic any_hot_i,
  input  logic at_limit_i,
  input  logic expired_i,
  output logic step_clr_o,
  output logic step_load_o,
  output logic step_inc_o,
  output logic tmr_load_o,
  output logic tmr_run_o,
  output logic busy_o,
  output logic done_o,
  output logic timeout_o,
  output logic launch_o,
  output logic eval_go_o,
  output logic eval_clr_o,
  output logic ph_req_o,
  output logic ph_set_o
);

  lcs_state_e st_q, st_nxt;
  logic set_q, set_nxt;
  logic done_q, done_nxt;
  logic to_q, to_nxt;

  always_comb begin
    st_nxt      = st_q;
    set_nxt     = set_q;
    done_nxt    = done_q;
    to_nxt      = to_q;
    step_clr_o  = 1'b0;
    step_load_o = 1'b0;
    step_inc_o  = 1'b0;
    tmr_load_o  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_nxt     = ST_CLEAR;
          step_clr_o = 1'b1;
          set_nxt    = 1'b1;
          done_nxt   = 1'b0;
          to_nxt     = 1'b0;
        end
      end
      ST_CLEAR: st_nxt = ST_PREQ;
      ST_PREQ: begin
        if (!ph_busy_i) st_nxt = ST_PWAIT;
      end
      ST_PWAIT: begin
        if (ph_ack_i) begin
          st_nxt     = ST_LAUNCH;
          tmr_load_o = 1'b1;
          if (set_q) step_load_o = 1'b1;
          else       step_inc_o  = 1'b1;
        end
      end
      ST_LAUNCH: begin
        if (expired_i) st_nxt = ST_EVAL;
      end
      ST_EVAL: begin
        if (any_hot_i && !at_limit_i) begin
          st_nxt  = ST_PREQ;
          set_nxt = 1'b0;
        end else begin
          st_nxt   = ST_IDLE;
          done_nxt = 1'b1;
          to_nxt   = any_hot_i;
        end
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  assign tmr_run_o = (st_q == ST_LAUNCH);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      set_q      <= 1'b0;
      done_q     <= 1'b0;
      to_q       <= 1'b0;
      busy_o     <= 1'b0;
      launch_o   <= 1'b0;
      eval_go_o  <= 1'b0;
      eval_clr_o <= 1'b0;
      ph_req_o   <= 1'b0;
      ph_set_o   <= 1'b0;
    end else begin
      st_q       <= st_nxt;
      set_q      <= set_nxt;
      done_q     <= done_nxt;
      to_q       <= to_nxt;
      busy_o     <= (st_nxt != ST_IDLE);
      launch_o   <= (st_nxt == ST_LAUNCH) || (st_nxt == ST_EVAL);
      eval_go_o  <= (st_nxt == ST_EVAL);
      eval_clr_o <= (st_nxt == ST_CLEAR);
      ph_req_o   <= (st_nxt == ST_PREQ);
      ph_set_o   <= set_nxt;
    end
  end

  assign done_o    = done_q;
  assign timeout_o = to_q;

endmodule

// File: rtl/lcs_sweep_ctrl.sv
module lcs_sweep_ctrl #(
  parameter int N_OUT      = 8,
  parameter int MAX_STEP   = 2047,
  parameter int START_STEP = 1,
  parameter int SETTLE_CYC = 4,
  localparam int STEP_W    = $clog2(MAX_STEP + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o,
  output logic [STEP_W-1:0] step_o,
  output logic              eval_clr_o,
  output logic              eval_go_o,
  output logic              launch_o,
  output logic              ph_req_o,
  output logic              ph_set_o,
  input  logic              ph_busy_i,
  input  logic              ph_ack_i,
  input  logic [N_OUT-1:0]  xor_i
);

  localparam int CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;

  logic any_hot;
  logic at_limit, expired;
  logic step_clr, step_load, step_inc, tmr_load, tmr_run;

  assign any_hot = |xor_i;

  lcs_seq_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .ph_busy_i  (ph_busy_i),
    .ph_ack_i   (ph_ack_i),
    .any_hot_i  (any_hot),
    .at_limit_i (at_limit),
    .expired_i  (expired),
    .step_clr_o (step_clr),
    .step_load_o(step_load),
    .step_inc_o (step_inc),
    .tmr_load_o (tmr_load),
    .tmr_run_o  (tmr_run),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .timeout_o  (timeout_o),
    .launch_o   (launch_o),
    .eval_go_o  (eval_go_o),
    .eval_clr_o (eval_clr_o),
    .ph_req_o   (ph_req_o),
    .ph_set_o   (ph_set_o)
  );

  lcs_step_ctr #(
    .MAX_STEP  (MAX_STEP),
    .START_STEP(START_STEP),
    .STEP_W    (STEP_W)
  ) u_step (
    .clk       (clk),
    .rst       (rst),
    .clr_i     (step_clr),
    .load_i    (step_load),
    .inc_i     (step_inc),
    .step_o    (step_o),
    .at_limit_o(at_limit)
  );

  lcs_dwell_tmr #(
    .SETTLE_CYC(SETTLE_CYC),
    .CNT_W     (CNT_W)
  ) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load_i   (tmr_load),
    .run_i    (tmr_run),
    .expired_o(expired)
  );

endmodule

// File: rtl/lcs_sweep_ctrl_chk.sv
module lcs_sweep_ctrl_chk #(
  parameter int MAX_STEP   = 2047,
  parameter int START_STEP = 1,
  localparam int STEP_W    = $clog2(MAX_STEP + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              timeout_o,
  input logic [STEP_W-1:0] step_o,
  input logic              eval_clr_o,
  input logic              eval_go_o,
  input logic              launch_o,
  input logic              ph_req_o,
  input logic              ph_busy_i
);

  // R2
  a_r2_start_clears: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> (eval_clr_o && busy_o && !done_o));

  // R3
  a_r3_strobes_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({eval_clr_o, eval_go_o, ph_req_o}));

  // R4
  a_r4_req_held: assert property (@(posedge clk) disable iff (rst)
    (ph_req_o && ph_busy_i) |=> ph_req_o);

  a_r4_no_launch_on_req: assert property (@(posedge clk) disable iff (rst)
    ph_req_o |-> !launch_o);

  // R5
  a_r5_eval_in_launch: assert property (@(posedge clk) disable iff (rst)
    eval_go_o |-> launch_o);

  // R6
  a_r6_step_moves_by_one: assert property (@(posedge clk) disable iff (rst)
    !$stable(step_o) |-> ((step_o == $past(step_o) + 1'b1) ||
                          (step_o == STEP_W'(START_STEP)) || (step_o == '0)));

  // R7
  a_r7_end_only_after_eval: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> (done_o && $past(eval_go_o)));

  a_r7_done_idle: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  // R8
  a_r8_timeout_with_done: assert property (@(posedge clk) disable iff (rst)
    timeout_o |-> done_o);

  a_r8_step_in_range: assert property (@(posedge clk) disable iff (rst)
    step_o <= STEP_W'(MAX_STEP));

  // R10
  a_r10_done_holds: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start_i) |=> done_o);

endmodule

bind lcs_sweep_ctrl lcs_sweep_ctrl_chk #(
  .MAX_STEP  (MAX_STEP),
  .START_STEP(START_STEP)
) u_chk (.*);

// File: tb/lcs_sweep_ctrl_tb.sv
module lcs_sweep_ctrl_tb;

  localparam int NO     = 4;
  localparam int MAXS   = 2047;
  localparam int STARTS = 1;
  localparam int SETTLE = 4;
  localparam int LAT    = 12;
  localparam int STEPW  = 11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic ph_busy = 1'b0;
  logic ph_ack = 1'b0;
  logic [NO-1:0] xr = '0;

  logic busy, done, tout, launch, go, clr, req, pset;
  logic [STEPW-1:0] step;

  lcs_sweep_ctrl #(
    .N_OUT     (NO),
    .MAX_STEP  (MAXS),
    .START_STEP(STARTS),
    .SETTLE_CYC(SETTLE)
  ) u_dut (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start),
    .busy_o    (busy),
    .done_o    (done),
    .timeout_o (tout),
    .step_o    (step),
    .eval_clr_o(clr),
    .eval_go_o (go),
    .launch_o  (launch),
    .ph_req_o  (req),
    .ph_set_o  (pset),
    .ph_busy_i (ph_busy),
    .ph_ack_i  (ph_ack),
    .xor_i     (xr)
  );

  always #10 clk = ~clk;

  int thr [NO];
  int n_chk = 0;
  int n_bad = 0;
  bit acc_q = 1'b0;
  bit inj = 1'b0;
  int sh_cnt = 0;

  // reference model state
  int m = 0, mcnt = 0, mstep = 0;
  bit mset = 0, mdone = 0, mto = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
    end
  endtask

  // shifter acceptance seen at the edge
  always @(posedge clk) acc_q <= req && !ph_busy;

  // behavioural reference, advanced on each edge from sampled inputs
  always @(posedge clk) begin
    if (rst) begin
      m = 0; mcnt = 0; mstep = 0; mset = 0; mdone = 0; mto = 0;
    end else begin
      case (m)
        0: if (start) begin m = 1; mstep = 0; mset = 1; mdone = 0; mto = 0; end
        1: m = 2;
        2: if (!ph_busy) m = 3;
        3: if (ph_ack) begin
             mstep = mset ? STARTS : mstep + 1;
             m = 4; mcnt = SETTLE - 1;
           end
        4: if (mcnt == 0) m = 5; else mcnt--;
        5: if ((|xr) && mstep < MAXS) begin m = 2; mset = 0; end
           else begin m = 0; mdone = 1; mto = |xr; end
        default: m = 0;
      endcase
    end
  end

  // compare, then shifter model and path model, away from the edge
  always @(negedge clk) begin
    if (!rst) begin
      chk(busy == (m != 0), "R2/R7 busy", busy, m != 0);
      chk(done == mdone, "R7/R10 done", done, mdone);
      chk(tout == mto, "R8 timeout", tout, mto);
      chk(step == STEPW'(mstep), "R3/R6 step", step, mstep);
      chk(launch == (m == 4 || m == 5), "R5 launch", launch, m == 4 || m == 5);
      chk(go == (m == 5), "R5 eval strobe", go, m == 5);
      chk(clr == (m == 1), "R2 clear strobe", clr, m == 1);
      chk(req == (m == 2), "R4 request", req, m == 2);
      if (m == 2) chk(pset == mset, "R3/R6 request kind", pset, mset);
    end
    ph_ack = 1'b0;
    if (inj) begin ph_ack = 1'b1; inj = 1'b0; end
    if (acc_q) begin
      ph_busy = 1'b1; sh_cnt = LAT;
    end else if (ph_busy) begin
      sh_cnt--;
      if (sh_cnt == 0) begin ph_busy = 1'b0; ph_ack = 1'b1; end
    end
    for (int j = 0; j < NO; j++) xr[j] = launch && (thr[j] > int'(step));
  end

  task automatic sweep(input int t0, input int t1, input int t2, input int t3,
                       input bit glitch, input int exp_step, input bit exp_to,
                       input string rq);
    int cyc;
    int k;
    bit did_inj;
    thr[0] = t0; thr[1] = t1; thr[2] = t2; thr[3] = t3;
    did_inj = 1'b0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cyc = 0;
    while (busy && cyc < 60000) begin
      cyc++;
      if (glitch && cyc == 30) start = 1'b1;   // R9 start while busy
      if (glitch && cyc == 31) start = 1'b0;
      if (glitch && launch && !did_inj && cyc > 40) begin
        did_inj = 1'b1;
        @(posedge clk); inj = 1'b1;            // R11 stray acknowledge
      end
      @(negedge clk);
    end
    k = exp_step - STARTS + 1;
    chk(done == 1'b1, {rq, " done after sweep"}, done, 1);
    chk(int'(step) == exp_step, {rq, " final step"}, step, exp_step);
    chk(tout == exp_to, {rq, " timeout flag"}, tout, exp_to);
    chk(cyc == 1 + k * (LAT + SETTLE + 3), {rq, " R12 busy cycles"},
        cyc, 1 + k * (LAT + SETTLE + 3));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk({busy, done, tout, launch, go, clr, req} == 7'd0, "R1 outputs in reset",
        {busy, done, tout, launch, go, clr, req}, 0);
    chk(step == '0, "R1 step in reset", step, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R1 idle after reset", busy, 0);

    sweep(5, 3, 9, 0, 1'b0, 9, 1'b0, "R7 mixed thresholds");
    repeat (10) @(negedge clk);
    chk(done == 1'b1, "R10 done holds while idle", done, 1);
    sweep(0, 0, 0, 0, 1'b0, STARTS, 1'b0, "R3 quiet outputs");
    sweep(2, 0, 0, 1, 1'b0, 2, 1'b0, "R6 single advance");
    sweep(7, 0, 6, 0, 1'b1, 7, 1'b0, "R9 R11 stray start and ack");
    sweep(4000, 0, 0, 0, 1'b0, MAXS, 1'b1, "R8 step limit");
    repeat (5) @(negedge clk);
    chk(req == 1'b0 && tout == 1'b1, "R8 no request after limit", req, 0);
    sweep(1, 1, 1, 1, 1'b0, STARTS, 1'b0, "R10 flags cleared by start");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule